// File: doc/BRIEF.md
# Codec Control Register Writer

This block is a two-wire bus master that writes one configuration word into an audio codec per request. The codec's control registers can only be written, never read back. A caller presents a 7-bit register index and a 9-bit register value with a one-cycle request. The block then runs one complete write on the bus: a START, a fixed address byte, two data bytes that carry the index and the value, an acknowledge slot after each byte, and a STOP. The caller decides the order of the register writes, and it watches `busy` and `done` to move from one write to the next.

SDA is open-drain. The block only ever pulls the line low through `sda_oe` and reads the line back on `sda_in`. SCL is a plain output level. The bus rate is set by `QUARTER_CYCLES`, which is the number of system clocks in one quarter of an SCL period; 125 quarters of a 50 MHz clock give 100 kHz. If the codec leaves any acknowledge slot high, the transfer ends at once with a STOP, and an error flag is reported together with the completion pulse.

Top module: `codec_reg_writer`

## Requirements
- R1: While `busy` is low (including right after reset), `scl` is 1 and `sda_oe` is 0, so the bus is idle and released.
- R2: A request is taken only in a cycle where `busy` is low and `req_valid` is 1, and `busy` goes high from the next cycle. A `req_valid` or a change of request fields while `busy` is high has no effect on the transfer in progress.
- R3: The first byte after START is 8'h34: the 7-bit device address 7'b0011010 followed by a write bit of 0. The block never issues a read or a repeated START.
- R4: The second byte is {index[6:0], value[8]} and the third byte is value[7:0]. Each byte is sent MSB first, and each is followed by an acknowledge slot in which `sda_oe` is 0.
- R5: `sda_oe` changes while `scl` is high in only two places: it rises in the first quarter after a request is taken (START), and it falls in the last quarter of the STOP. Every other SDA change happens while SCL is low.
- R6: Each bus quarter lasts `QUARTER_CYCLES` clocks. START takes 2 quarters (SCL high then low, SDA low). Each bit takes 4 quarters: SCL low with the old SDA, SCL low with the new SDA, then two quarters with SCL high. STOP takes 4 quarters: SCL low with SDA released, SCL low with SDA low, SCL high with SDA low, and SCL high with SDA released.
- R7: `sda_in` is sampled at the end of the third quarter of each acknowledge slot. If it reads 1, the STOP follows directly after that slot and no further bytes are sent.
- R8: `done` is high for exactly one cycle, in the cycle after the last STOP quarter ends, and `busy` is low in that same cycle.
- R9: `ack_error` takes the value 1 together with `done` if any acknowledge slot read 1, and 0 otherwise. It keeps that value until the next request is taken, which clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request one register write |
| req_index | input | 7 | Register index for the write |
| req_value | input | 9 | Register value for the write |
| busy | output | 1 | A transfer is in progress |
| done | output | 1 | One-cycle pulse when a transfer ends |
| ack_error | output | 1 | The last transfer saw a NACK |
| scl | output | 1 | Bus clock level |
| sda_oe | output | 1 | Pull SDA low when 1 |
| sda_in | input | 1 | Level read back from SDA |

## Verification
The in-module assertions check, on every cycle, the rules that hold at all times. These are: an idle, released bus whenever no transfer is running; SDA moving under a high SCL only inside START or STOP; SDA released through every acknowledge slot; a one-cycle `done` that coincides with the fall of `busy`; an error flag that changes only at completion or at acceptance; and a bounded quarter counter. Only the bench's scenarios can show the rest. The exact byte contents for different indices and values are checked by a bus-side decoder. The quarter-by-quarter timing is compared against a reference model on every clock. A NACK on each of the three bytes must cut the transfer short at the right place. A request raised during a transfer must be ignored, and a held request must be taken back-to-back in the cycle right after `done`.

// File: rtl/codec_wr_pkg.sv
package codec_wr_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_START = 2'd1,
        ST_DATA  = 2'd2,
        ST_STOP  = 2'd3
    } wr_state_e;
endpackage

// File: rtl/codec_wr_tick.sv
module codec_wr_tick #(
    parameter int QUARTER_CYCLES = 125
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    localparam int CNT_W = $clog2(QUARTER_CYCLES > 1 ? QUARTER_CYCLES : 2);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    assign tick = run && (cnt_q == CNT_W'(QUARTER_CYCLES - 1));

    always_comb begin
        if (!run)      cnt_d = '0;
        else if (tick) cnt_d = '0;
        else           cnt_d = cnt_q + CNT_W'(1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // R6: the quarter counter never passes the quarter length
    p_quarter_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q < CNT_W'(QUARTER_CYCLES));
endmodule

// File: rtl/codec_wr_frame.sv
module codec_wr_frame #(
    parameter logic [6:0] DEV_ADDR = 7'h1A,
    parameter int IDX_W = 7,
    parameter int VAL_W = 9
) (
    input  logic [IDX_W-1:0]           index,
    input  logic [VAL_W-1:0]           value,
    output logic [8+IDX_W+VAL_W-1:0]   frame
);
    // address byte with write bit, then index and value packed MSB first
    assign frame = {DEV_ADDR, 1'b0, index, value};
endmodule

// File: rtl/codec_reg_writer.sv
module codec_reg_writer
    import codec_wr_pkg::*;
#(
    parameter int QUARTER_CYCLES = 125,
    parameter logic [6:0] DEV_ADDR = 7'h1A,
    parameter int IDX_W = 7,
    parameter int VAL_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic [IDX_W-1:0] req_index,
    input  logic [VAL_W-1:0] req_value,
    output logic             busy,
    output logic             done,
    output logic             ack_error,
    output logic             scl,
    output logic             sda_oe,
    input  logic             sda_in
);
    localparam int FRAME_W = 8 + IDX_W + VAL_W;
    localparam int NBYTES  = FRAME_W / 8;
    localparam int BYTE_W  = $clog2(NBYTES);
    localparam logic [3:0] ACK_SLOT = 4'd8;

    typedef struct packed {
        wr_state_e         st;
        logic [1:0]        ph;
        logic [3:0]        bitn;
        logic [BYTE_W-1:0] byten;
        logic [FRAME_W-1:0] sh;
        logic              scl;
        logic              oe;
        logic              nack;
        logic              err;
        logic              done;
    } regs_t;

    regs_t r_d, r_q;
    logic [FRAME_W-1:0] frame_w;
    logic tick;

    codec_wr_frame #(.DEV_ADDR(DEV_ADDR), .IDX_W(IDX_W), .VAL_W(VAL_W)) u_frame (
        .index (req_index),
        .value (req_value),
        .frame (frame_w)
    );

    codec_wr_tick #(.QUARTER_CYCLES(QUARTER_CYCLES)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (r_q.st != ST_IDLE),
        .tick  (tick)
    );

    always_comb begin
        r_d = r_q;
        r_d.done = 1'b0;
        unique case (r_q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    r_d.st    = ST_START;
                    r_d.ph    = 2'd0;
                    r_d.bitn  = '0;
                    r_d.byten = '0;
                    r_d.sh    = frame_w;
                    r_d.scl   = 1'b1;
                    r_d.oe    = 1'b1;
                    r_d.nack  = 1'b0;
                    r_d.err   = 1'b0;
                end
            end
            ST_START: begin
                if (tick) begin
                    if (r_q.ph == 2'd0) begin
                        r_d.ph  = 2'd1;
                        r_d.scl = 1'b0;
                    end else begin
                        r_d.st    = ST_DATA;
                        r_d.ph    = 2'd0;
                        r_d.bitn  = '0;
                        r_d.byten = '0;
                    end
                end
            end
            ST_DATA: begin
                if (tick) begin
                    unique case (r_q.ph)
                        2'd0: begin
                            r_d.ph = 2'd1;
                            r_d.oe = (r_q.bitn == ACK_SLOT) ? 1'b0 : ~r_q.sh[FRAME_W-1];
                        end
                        2'd1: begin
                            r_d.ph  = 2'd2;
                            r_d.scl = 1'b1;
                        end
                        2'd2: begin
                            r_d.ph = 2'd3;
                            if (r_q.bitn == ACK_SLOT) r_d.nack = sda_in;
                        end
                        default: begin
                            r_d.ph  = 2'd0;
                            r_d.scl = 1'b0;
                            if (r_q.bitn == ACK_SLOT) begin
                                if (r_q.nack || r_q.byten == BYTE_W'(NBYTES - 1)) begin
                                    r_d.st = ST_STOP;
                                end else begin
                                    r_d.byten = r_q.byten + BYTE_W'(1);
                                    r_d.bitn  = '0;
                                end
                            end else begin
                                r_d.bitn = r_q.bitn + 4'd1;
                                r_d.sh   = r_q.sh << 1;
                            end
                        end
                    endcase
                end
            end
            default: begin
                if (tick) begin
                    unique case (r_q.ph)
                        2'd0: begin
                            r_d.ph = 2'd1;
                            r_d.oe = 1'b1;
                        end
                        2'd1: begin
                            r_d.ph  = 2'd2;
                            r_d.scl = 1'b1;
                        end
                        2'd2: begin
                            r_d.ph = 2'd3;
                            r_d.oe = 1'b0;
                        end
                        default: begin
                            r_d.st   = ST_IDLE;
                            r_d.ph   = 2'd0;
                            r_d.done = 1'b1;
                            r_d.err  = r_q.nack;
                        end
                    endcase
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q       <= '0;
            r_q.st    <= ST_IDLE;
            r_q.scl   <= 1'b1;
            r_q.oe    <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign busy      = (r_q.st != ST_IDLE);
    assign done      = r_q.done;
    assign ack_error = r_q.err;
    assign scl       = r_q.scl;
    assign sda_oe    = r_q.oe;

    // R1: idle bus is released with SCL high
    p_idle_bus_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (scl && !sda_oe));

    // R5: SDA moves under a high SCL only during START or STOP
    p_sda_steady_high_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (scl && $past(scl) && (sda_oe != $past(sda_oe)))
            |-> (r_q.st == ST_START || r_q.st == ST_STOP));

    // R4: acknowledge slot keeps SDA released once the old bit is dropped
    p_ack_release_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_DATA && r_q.bitn == ACK_SLOT && r_q.ph != 2'd0) |-> !sda_oe);

    // R8: completion is a single-cycle pulse coinciding with busy falling
    p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    p_done_with_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && $past(busy)));

    // R9: error flag moves only at completion or when a request is taken
    p_err_change_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ack_error) |-> (done || $rose(busy)));
endmodule

// File: tb/codec_reg_writer_test.sv
module codec_reg_writer_test;
    localparam int Q = 3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_valid = 1'b0;
    logic [6:0] req_index = '0;
    logic [8:0] req_value = '0;
    logic       busy, done, ack_error, scl, sda_oe;
    logic       slave_low;
    logic       sda_line;

    int checks = 0;
    int fails = 0;
    bit finished = 1'b0;
    bit cmp_on = 1'b0;
    int nack_cfg = 3;

    // reference model state
    bit          m_active;
    int          m_t;
    bit          m_done;
    bit          m_err;
    logic [23:0] m_fr;
    int          m_nb;
    int          m_nq;

    // bus-side decoder
    logic        prev_scl;
    logic [27:0] cap;
    int          mon_n;

    always #5 clk = ~clk;

    assign sda_line = ~(sda_oe | slave_low);

    codec_reg_writer #(.QUARTER_CYCLES(Q)) uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_index (req_index),
        .req_value (req_value),
        .busy      (busy),
        .done      (done),
        .ack_error (ack_error),
        .scl       (scl),
        .sda_oe    (sda_oe),
        .sda_in    (sda_line)
    );

    function automatic logic bit_oe(logic [23:0] fr, int slot);
        if (slot % 9 == 8) return 1'b0;
        return ~fr[23 - (slot / 9) * 8 - (slot % 9)];
    endfunction

    // expected {scl, sda_oe} for quarter q of a transfer
    function automatic logic [1:0] exp_bus(int q, logic [23:0] fr, int nbytes);
        int r, slot, ph, s;
        logic cur, prv;
        if (q == 0) return 2'b11;
        if (q == 1) return 2'b01;
        r = q - 2;
        if (r < nbytes * 36) begin
            slot = r / 4;
            ph   = r % 4;
            cur  = bit_oe(fr, slot);
            prv  = (slot == 0) ? 1'b1 : bit_oe(fr, slot - 1);
            if (ph == 0) return {1'b0, prv};
            if (ph == 1) return {1'b0, cur};
            return {1'b1, cur};
        end
        s = r - nbytes * 36;
        case (s)
            0: return 2'b00;
            1: return 2'b01;
            2: return 2'b11;
            default: return 2'b10;
        endcase
    endfunction

    // slave pulls SDA low in acknowledge slots it accepts
    always_comb begin
        int r, slot;
        slave_low = 1'b0;
        if (m_active) begin
            r = m_t / Q - 2;
            if (r >= 0 && r < ((m_nb < 3) ? m_nb + 1 : 3) * 36) begin
                slot = r / 4;
                if (slot % 9 == 8 && (slot / 9) != m_nb && (r % 4) != 0)
                    slave_low = 1'b1;
            end
        end
    end

    always @(posedge clk) begin
        if (!rst_n) begin
            m_active <= 1'b0;
            m_t      <= 0;
            m_done   <= 1'b0;
            m_err    <= 1'b0;
            m_nb     <= 3;
            m_nq     <= 0;
        end else begin
            m_done <= 1'b0;
            if (m_active) begin
                if (m_t + 1 == m_nq * Q) begin
                    m_active <= 1'b0;
                    m_done   <= 1'b1;
                    m_err    <= (m_nb < 3);
                end else begin
                    m_t <= m_t + 1;
                end
            end else if (req_valid) begin
                m_active <= 1'b1;
                m_t      <= 0;
                m_fr     <= {8'h34, req_index, req_value};
                m_nb     <= nack_cfg;
                m_nq     <= 2 + ((nack_cfg < 3) ? nack_cfg + 1 : 3) * 36 + 4;
                m_err    <= 1'b0;
            end
        end
    end

    always @(posedge clk) begin
        prev_scl <= scl;
        if (!rst_n || (!m_active && req_valid)) begin
            mon_n <= 0;
            cap   <= '0;
        end else if (scl && !prev_scl) begin
            cap   <= {cap[26:0], sda_line};
            mon_n <= mon_n + 1;
        end
    end

    task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h at %0t", tag, what, act, exp, $time);
        end
    endtask

    // per-clock comparison against the model, away from the active edge
    always @(negedge clk) begin
        logic [1:0] eb;
        if (cmp_on) begin
            if (m_active) begin
                eb = exp_bus(m_t / Q, m_fr, (m_nb < 3) ? m_nb + 1 : 3);
                check("R6", "scl", 32'(scl), 32'(eb[1]));
                check("R4", "sda_oe", 32'(sda_oe), 32'(eb[0]));
            end else begin
                check("R1", "scl idle", 32'(scl), 32'd1);
                check("R1", "sda_oe idle", 32'(sda_oe), 32'd0);
            end
            check("R2", "busy", 32'(busy), 32'(m_active));
            check("R8", "done", 32'(done), 32'(m_done));
            check("R9", "ack_error", 32'(ack_error), 32'(m_err));
        end
    end

    task automatic wait_idle();
        @(negedge clk);
        while (m_active) @(negedge clk);
    endtask

    task automatic do_write(logic [6:0] idx, logic [8:0] val, int nb);
        @(negedge clk);
        nack_cfg  = nb;
        req_index = idx;
        req_value = val;
        req_valid = 1'b1;
        @(negedge clk);
        while (!m_active) @(negedge clk);
        req_valid = 1'b0;
        wait_idle();
        if (nb >= 3) begin
            check("R3", "rising edges", 32'(mon_n), 32'd28);
            check("R3", "address byte", 32'(cap[27:20]), 32'h34);
            check("R4", "index byte", 32'(cap[18:11]), 32'({idx, val[8]}));
            check("R4", "value byte", 32'(cap[9:2]), 32'(val[7:0]));
            check("R4", "acks seen", 32'({cap[19], cap[10], cap[1]}), 32'd0);
        end else begin
            check("R7", "edges before abort", 32'(mon_n), 32'((nb + 1) * 9 + 1));
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            fails++;
            checks++;
            $display("FAIL watchdog: actual hang expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        cmp_on = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1", "reset scl", 32'(scl), 32'd1);
        check("R1", "reset busy", 32'(busy), 32'd0);
        @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);

        do_write(7'h01, 9'h12F, 3);
        do_write(7'h7F, 9'h000, 3);
        do_write(7'h2A, 9'h155, 3);
        do_write(7'h00, 9'h1FF, 3);

        // R7 / R9: NACK on each byte, flag cleared by the next good write
        do_write(7'h11, 9'h0AA, 0);
        check("R9", "flag held", 32'(ack_error), 32'd1);
        do_write(7'h22, 9'h055, 1);
        do_write(7'h33, 9'h1C3, 2);
        do_write(7'h05, 9'h0F0, 3);
        check("R9", "flag cleared", 32'(ack_error), 32'd0);

        // R2: request during busy ignored, then held request taken back-to-back
        @(negedge clk);
        nack_cfg  = 3;
        req_index = 7'h0C;
        req_value = 9'h10F;
        req_valid = 1'b1;
        @(negedge clk);
        while (!m_active) @(negedge clk);
        req_index = 7'h5A;
        req_value = 9'h0E1;
        while (!m_done) @(negedge clk);
        @(negedge clk);
        check("R2", "back-to-back accept", 32'(busy), 32'd1);
        req_valid = 1'b0;
        wait_idle();
        check("R4", "second index byte", 32'(cap[18:11]), 32'({7'h5A, 1'b0}));
        check("R4", "second value byte", 32'(cap[9:2]), 32'h0E1);

        repeat (5) @(negedge clk);
        if (!finished) begin
            finished = 1'b1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule